// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block keeps the protection state of a serial non-volatile memory and rules on every write request that reaches it. It stores a write-protect-enable flag, a two-bit block-protect field and a write-enable latch, and shows the write timer's busy line. A serial front-end feeds it decoded command strobes, the address of an array write and the raw data bits of a status write. A write timer feeds it a busy line. The block answers with one-cycle allow or deny pulses, and with a status byte for readback.

A status write is committed only when chip select rises after exactly one data byte. At that point the latch must be set, the timer must be idle and the hardware protect pin must not be blocking. The protect pin counts only while the stored enable flag is 1. It can cancel a status write during the serial phase. It cannot touch a status write once that write is committed. An array write is checked against the protected region, which is chosen by the block-protect field and taken from the top of the address space.

Top module: `sr_wp_ctrl`

## Requirements
- R1: After reset, status bits 7, 3:2 and 1 read 0.
- R2: Command code 0 sets the write-enable latch (status bit 1). Command code 1 clears it. Both codes are ignored while `busy_in` is high.
- R3: Command code 2 opens a status write. The data bits that follow are taken MSB first. If exactly 8 bits arrive before `cs_n` rises, with the latch set, `busy_in` low and the pin not blocking, then `sr_wr_go` pulses for one cycle. Bit 7 of the byte is stored as the protect-enable flag and bits 3:2 as the block-protect field. The other bits are not stored.
- R4: A status write with any bit count other than 8 (fewer or more) is discarded. `sr_wr_deny` pulses and the stored bits do not change.
- R5: A status write made while the latch is clear is denied.
- R6: With the protect-enable flag at 1, `wp_n` low when `cs_n` rises denies the status write.
- R7: With the protect-enable flag at 1, `wp_n` low in any cycle while `cs_n` is low during a status write denies that write, even if `wp_n` is high again when `cs_n` rises.
- R8: With the protect-enable flag at 0, `wp_n` has no effect, and status writes commit with it held low.
- R9: After a committed status write, `wp_n` going low while `busy_in` is high leaves the stored bits unchanged.
- R10: Command code 3 checks `addr` and pulses `arr_wr_go` or `arr_wr_deny` in the next cycle. The block-protect field selects the protected region: 00 protects nothing, 01 protects addresses whose top two bits are 11, 10 protects addresses whose top bit is 1, and 11 protects every address. A write is denied if its address is protected, if the latch is clear, or if `busy_in` is high.
- R11: Any deny clears the latch. After a go, the latch stays set until `busy_in` falls, and then it clears.
- R12: Status byte layout: bit 7 is the protect-enable flag, bits 6:4 read 0, bits 3:2 are the block-protect field, bit 1 is the latch, and bit 0 follows `busy_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| cmd_stb | input | 1 | Decoded command valid for one cycle |
| cmd_code | input | 2 | 0 latch set, 1 latch clear, 2 status write, 3 array write |
| addr | input | ADDR_W | Target address of an array write |
| bit_stb | input | 1 | One serial data bit valid |
| bit_val | input | 1 | Value of that data bit |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| busy_in | input | 1 | Write timer running |
| status_o | output | 8 | Status byte for readback |
| sr_wr_go | output | 1 | Status write committed (one-cycle pulse) |
| sr_wr_deny | output | 1 | Status write refused (one-cycle pulse) |
| arr_wr_go | output | 1 | Array write allowed (one-cycle pulse) |
| arr_wr_deny | output | 1 | Array write refused (one-cycle pulse) |

## Verification
An array-write decision appears one clock after the edge that samples `cmd_stb`. A status-write decision appears, together with the new stored bits, one clock after the first edge that sees `cs_n` high. The latch reacts at the edge that sees a command or the fall of `busy_in`. Status bit 0 moves in the same cycle as `busy_in`. The bench changes inputs on falling edges and reads outputs on the falling edge that follows the deciding rising edge, so every read lands exactly in the cycle where the result is due. The block-protect field and all 64 addresses of a 6-bit configuration are swept exhaustively against a region computed arithmetically, and all 256 status bytes are swept in the same way.

// File: rtl/srwp_pkg.sv
// Package: shared command codes, status bit positions and protection
// encodings for the status register write-protection controller.
package srwp_pkg;

    typedef enum logic [1:0] {
        CMD_LATCH_SET = 2'd0,
        CMD_LATCH_CLR = 2'd1,
        CMD_SR_WRITE  = 2'd2,
        CMD_ARR_WRITE = 2'd3
    } srwp_cmd_e;

    typedef enum logic [1:0] {
        PROT_NONE    = 2'd0,
        PROT_QUARTER = 2'd1,
        PROT_HALF    = 2'd2,
        PROT_ALL     = 2'd3
    } srwp_prot_e;

    localparam int ST_PEN_BIT  = 7;
    localparam int ST_BP_HI    = 3;
    localparam int ST_BP_LO    = 2;
    localparam int ST_WEL_BIT  = 1;
    localparam int ST_BUSY_BIT = 0;

endpackage

// File: rtl/srwp_range.sv
// Module: srwp_range
// Purely combinational check of whether an address falls inside the
// region protected by the block-protect field. The region is always
// taken from the top of the address space.
// Assumes ADDR_W >= 2 so that a quarter can be told apart.
module srwp_range
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  srwp_prot_e        prot,
    output logic              hit
);

    localparam int TOP = ADDR_W - 1;

    // Compare the upper address bits against the selected region.
    always_comb begin
        unique case (prot)
            PROT_NONE:    hit = 1'b0;
            PROT_QUARTER: hit = addr[TOP] & addr[TOP-1];
            PROT_HALF:    hit = addr[TOP];
            default:      hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/srwp_session.sv
// Module: srwp_session
// Tracks one status-write session from its command strobe to the rising
// edge of chip select. It counts the data bits (saturating one past a
// full byte), assembles them MSB first, and records any protect-pin
// drop while chip select is low. When chip select rises, it raises
// either a commit or a deny request for that cycle.
// Assumes wp_n and cs_n are already synchronous to clk.
module srwp_session #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              start,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              pen,
    input  logic              wp_n,
    input  logic              wel,
    input  logic              busy,
    output logic              commit_req,
    output logic              deny_req,
    output logic [DATA_W-1:0] data
);

    localparam int             CW      = $clog2(DATA_W + 2);
    localparam logic [CW-1:0]  CNT_MAX = CW'(DATA_W + 1);
    localparam logic [CW-1:0]  CNT_ONE = CW'(DATA_W);

    logic              cs_q;
    logic              active;
    logic              aborted;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] shreg;
    logic              cs_rise;
    logic              pin_block;
    logic              verdict_ok;

    assign cs_rise    = cs_n & ~cs_q;
    assign pin_block  = pen & ~wp_n;
    assign verdict_ok = (cnt == CNT_ONE) & wel & ~busy & ~aborted & ~pin_block;
    assign commit_req = active & cs_rise & verdict_ok;
    assign deny_req   = active & cs_rise & ~verdict_ok;
    assign data       = shreg;

    // Remember the previous chip-select level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    // Session state: open on start, close on chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            aborted <= 1'b0;
            cnt     <= '0;
            shreg   <= '0;
        end else if (start) begin
            active  <= 1'b1;
            aborted <= pin_block;
            cnt     <= '0;
            shreg   <= '0;
        end else if (active) begin
            if (cs_rise) begin
                active <= 1'b0;
            end else if (!cs_n) begin
                if (pin_block) aborted <= 1'b1;
                if (bit_stb && cnt != CNT_MAX) begin
                    cnt   <= cnt + 1'b1;
                    shreg <= {shreg[DATA_W-2:0], bit_val};
                end
            end
        end
    end

endmodule

// File: rtl/srwp_regs.sv
// Module: srwp_regs
// Holds the stored protection bits and the write-enable latch. The
// stored bits change only on a commit. The latch is set by its command,
// and cleared by its clear command, by any deny, or by the fall of the
// busy line. A set in the same cycle as a clear wins.
module srwp_regs
    import srwp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              busy,
    output logic              pen,
    output srwp_prot_e        prot,
    output logic              wel
);

    logic busy_q;
    logic busy_fall;

    assign busy_fall = busy_q & ~busy;

    // Delay the busy line by one cycle to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // Store protect-enable and block-protect bits on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen  <= 1'b0;
            prot <= PROT_NONE;
        end else if (commit) begin
            pen  <= wdata[ST_PEN_BIT];
            prot <= srwp_prot_e'(wdata[ST_BP_HI:ST_BP_LO]);
        end
    end

    // Write-enable latch with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                      wel <= 1'b0;
        else if (wel_set)                wel <= 1'b1;
        else if (wel_clr || busy_fall)   wel <= 1'b0;
    end

endmodule

// File: rtl/sr_wp_ctrl.sv
// Module: sr_wp_ctrl (top)
// Status register write-protection controller. It decodes the command
// strobes, rules on array writes against the protected region, passes
// status-write sessions to srwp_session, and registers every verdict
// as a one-cycle pulse.
// Assumes the front-end issues commands only while cs_n is low, and at
// most one command per cycle.
module sr_wp_ctrl
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cmd_stb,
    input  logic [1:0]        cmd_code,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              wp_n,
    input  logic              busy_in,
    output logic [7:0]        status_o,
    output logic              sr_wr_go,
    output logic              sr_wr_deny,
    output logic              arr_wr_go,
    output logic              arr_wr_deny
);

    localparam int DATA_W = 8;

    srwp_cmd_e         cmd;
    logic              pen;
    srwp_prot_e        prot;
    logic              wel;
    logic              prot_hit;
    logic              sr_commit;
    logic              sr_deny;
    logic [DATA_W-1:0] sr_data;
    logic              latch_set;
    logic              latch_clr_cmd;
    logic              sr_start;
    logic              arr_req;
    logic              arr_ok;
    logic              wel_clr;

    assign cmd = srwp_cmd_e'(cmd_code);

    // Decode command strobes and the array-write verdict.
    always_comb begin
        latch_set     = cmd_stb & (cmd == CMD_LATCH_SET) & ~busy_in;
        latch_clr_cmd = cmd_stb & (cmd == CMD_LATCH_CLR) & ~busy_in;
        sr_start      = cmd_stb & (cmd == CMD_SR_WRITE);
        arr_req       = cmd_stb & (cmd == CMD_ARR_WRITE);
        arr_ok        = wel & ~busy_in & ~prot_hit;
        wel_clr       = latch_clr_cmd | sr_deny | (arr_req & ~arr_ok);
    end

    srwp_range #(.ADDR_W(ADDR_W)) u_range (
        .addr (addr),
        .prot (prot),
        .hit  (prot_hit)
    );

    srwp_session #(.DATA_W(DATA_W)) u_session (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .start      (sr_start),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .pen        (pen),
        .wp_n       (wp_n),
        .wel        (wel),
        .busy       (busy_in),
        .commit_req (sr_commit),
        .deny_req   (sr_deny),
        .data       (sr_data)
    );

    srwp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (sr_commit),
        .wdata   (sr_data),
        .wel_set (latch_set),
        .wel_clr (wel_clr),
        .busy    (busy_in),
        .pen     (pen),
        .prot    (prot),
        .wel     (wel)
    );

    // Register the verdict pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_wr_go    <= 1'b0;
            sr_wr_deny  <= 1'b0;
            arr_wr_go   <= 1'b0;
            arr_wr_deny <= 1'b0;
        end else begin
            sr_wr_go    <= sr_commit;
            sr_wr_deny  <= sr_deny;
            arr_wr_go   <= arr_req & arr_ok;
            arr_wr_deny <= arr_req & ~arr_ok;
        end
    end

    // Assemble the readback byte.
    always_comb begin
        status_o                      = '0;
        status_o[ST_PEN_BIT]          = pen;
        status_o[ST_BP_HI:ST_BP_LO]   = prot;
        status_o[ST_WEL_BIT]          = wel;
        status_o[ST_BUSY_BIT]         = busy_in;
    end

endmodule

// File: rtl/srwp_chk.sv
// Module: srwp_chk
// Property checker for sr_wp_ctrl, observing only its ports. It is
// attached to the top module by the bind statement at the end of this file.
module srwp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_stb,
    input logic [1:0] cmd_code,
    input logic       busy_in,
    input logic [7:0] status_o,
    input logic       sr_wr_go,
    input logic       sr_wr_deny,
    input logic       arr_wr_go,
    input logic       arr_wr_deny
);

    // R2
    latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_code == 2'd0 && !busy_in) |=> status_o[1]);

    // R5
    sr_go_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_go |-> $past(status_o[1]));

    // R10
    arr_go_rules_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_go |-> ($past(status_o[1]) && !$past(busy_in)));

    // R11
    arr_deny_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_deny |-> !status_o[1]);

    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_in |=> $stable({status_o[7], status_o[3:2]}));

    // R12
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);

    // R3
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sr_wr_go, sr_wr_deny, arr_wr_go, arr_wr_deny}));

endmodule

bind sr_wp_ctrl srwp_chk u_srwp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_stb     (cmd_stb),
    .cmd_code    (cmd_code),
    .busy_in     (busy_in),
    .status_o    (status_o),
    .sr_wr_go    (sr_wr_go),
    .sr_wr_deny  (sr_wr_deny),
    .arr_wr_go   (arr_wr_go),
    .arr_wr_deny (arr_wr_deny)
);

// File: tb/sr_wp_ctrl_test.sv
// Bench for sr_wp_ctrl in a 6-bit address configuration. Inputs change
// on falling edges, and outputs are read on the next falling edge.
module sr_wp_ctrl_test;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          cmd_stb = 1'b0;
    logic [1:0]    cmd_code = 2'd0;
    logic [AW-1:0] addr = '0;
    logic          bit_stb = 1'b0;
    logic          bit_val = 1'b0;
    logic          wp_n = 1'b1;
    logic          busy_in = 1'b0;
    logic [7:0]    status_o;
    logic          sr_wr_go, sr_wr_deny, arr_wr_go, arr_wr_deny;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sr_wp_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_stb(cmd_stb),
        .cmd_code(cmd_code), .addr(addr), .bit_stb(bit_stb),
        .bit_val(bit_val), .wp_n(wp_n), .busy_in(busy_in),
        .status_o(status_o), .sr_wr_go(sr_wr_go), .sr_wr_deny(sr_wr_deny),
        .arr_wr_go(arr_wr_go), .arr_wr_deny(arr_wr_deny)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] code, input logic [AW-1:0] a);
        @(negedge clk);
        cmd_stb = 1'b1; cmd_code = code; addr = a;
        @(negedge clk);
        cmd_stb = 1'b0;
    endtask

    // Status write of nbits from byte b. wp_mid drops wp_n during the
    // first bit; wp_end is the pin level when cs_n rises.
    task automatic sr_write(input logic [7:0] b, input int nbits,
                            input bit wp_mid, input bit wp_end);
        @(negedge clk);
        cs_n = 1'b0;
        cmd(2'd2, '0);
        for (int i = 0; i < nbits; i++) begin
            bit_stb = 1'b1;
            bit_val = b[7 - (i % 8)];
            wp_n = (i == 0 && wp_mid) ? 1'b0 : 1'b1;
            @(negedge clk);
        end
        bit_stb = 1'b0;
        wp_n = wp_end;
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic busy_cycle();
        busy_in = 1'b1;
        @(negedge clk);
        busy_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_status(input logic [7:0] b);
        cmd(2'd0, '0);
        sr_write(b, 8, 1'b0, 1'b1);
        busy_cycle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 and R12: reset state, then bit 0 tracks busy_in
        chk("R1 reset status", status_o, 8'h00);
        busy_in = 1'b1;
        #1 chk("R12 busy bit", status_o[0], 1);
        busy_in = 1'b0;

        // R2: latch set and clear; ignored while busy
        cmd(2'd0, '0);
        chk("R2 latch set", status_o[1], 1);
        cmd(2'd1, '0);
        chk("R2 latch clear", status_o[1], 0);
        busy_in = 1'b1;
        cmd(2'd0, '0);
        chk("R2 set ignored busy", status_o[1], 0);
        busy_in = 1'b0;
        cmd(2'd0, '0);
        busy_in = 1'b1;
        cmd(2'd1, '0);
        chk("R2 clear ignored busy", status_o[1], 1);
        busy_in = 1'b0;
        @(negedge clk);
        chk("R11 busy fall clears", status_o[1], 0);

        // R3, R11, R12: every status byte
        for (int b = 0; b < 256; b++) begin
            cmd(2'd0, '0);
            sr_write(8'(b), 8, 1'b0, 1'b1);
            chk("R3 go", sr_wr_go, 1);
            chk("R3 stored", status_o & 8'hFE, (b & 8'h8C) | 8'h02);
            chk("R12 unused zero", status_o[6:4], 0);
            busy_cycle();
            chk("R11 clear after go", status_o[1], 0);
        end

        // R4: wrong bit counts are discarded
        set_status(8'h04);
        for (int n = 0; n <= 12; n++) begin
            if (n == 8) continue;
            cmd(2'd0, '0);
            sr_write(8'hFF, n, 1'b0, 1'b1);
            chk("R4 deny", sr_wr_deny, 1);
            chk("R4 unchanged", status_o, 8'h04);
        end

        // R5: latch clear denies
        sr_write(8'h08, 8, 1'b0, 1'b1);
        chk("R5 deny", sr_wr_deny, 1);
        chk("R5 unchanged", status_o, 8'h04);

        // R8: enable flag 0 ignores pin
        cmd(2'd0, '0);
        sr_write(8'h80, 8, 1'b1, 1'b0);
        chk("R8 go pin low", sr_wr_go, 1);
        busy_cycle();
        wp_n = 1'b1;
        chk("R8 stored", status_o, 8'h80);

        // R6: pin low at commit
        cmd(2'd0, '0);
        sr_write(8'h0C, 8, 1'b0, 1'b0);
        chk("R6 deny", sr_wr_deny, 1);
        wp_n = 1'b1;
        chk("R6 unchanged", status_o, 8'h80);

        // R7: pin drop mid-session
        cmd(2'd0, '0);
        sr_write(8'h0C, 8, 1'b1, 1'b1);
        chk("R7 deny", sr_wr_deny, 1);
        chk("R7 unchanged", status_o, 8'h80);

        // R9: pin low after commit has no effect
        cmd(2'd0, '0);
        sr_write(8'h88, 8, 1'b0, 1'b1);
        chk("R9 go", sr_wr_go, 1);
        busy_in = 1'b1;
        wp_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 kept", status_o & 8'hFD, 8'h89);
        busy_in = 1'b0;
        @(negedge clk);
        wp_n = 1'b1;
        chk("R9 after", status_o, 8'h88);
        set_status(8'h00);

        // R10, R11: protected region sweep
        for (int bp = 0; bp < 4; bp++) begin
            set_status(8'(bp << 2));
            for (int a = 0; a < (1 << AW); a++) begin
                for (int w = 0; w < 2; w++) begin
                    bit prot_e, go_e;
                    prot_e = (bp == 3) || (bp == 2 && a >= 32) ||
                             (bp == 1 && a >= 48);
                    go_e = (w == 1) && !prot_e;
                    if (w == 1) cmd(2'd0, '0);
                    cmd(2'd3, AW'(a));
                    chk("R10 go", arr_wr_go, int'(go_e));
                    chk("R10 deny", arr_wr_deny, int'(!go_e));
                    chk("R11 latch", status_o[1], int'(go_e));
                    if (go_e) busy_cycle();
                end
            end
        end

        // R10: busy denies
        set_status(8'h00);
        cmd(2'd0, '0);
        busy_in = 1'b1;
        cmd(2'd3, '0);
        chk("R10 busy deny", arr_wr_deny, 1);
        busy_in = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule